// File: doc/BRIEF.md
# Scanline Depth Buffer with Speculative Shadow Slots

This block resolves visibility for one scanline of pixels. Each request carries a pixel column, a new depth and a span ID. The span ID acts as a pointer that lets a later shader fetch colour data for the span. The block keeps the nearest surface seen so far at every pixel. Shading happens later, once a whole scanline has been resolved, so the buffer stores span IDs rather than colours.

Each pixel owns two storage slots, each holding a depth and a span ID, and one select bit that names the live slot. An accepted request writes its depth and span ID into the idle slot straight away, and in the same cycle it reads the live depth. One cycle later a comparator decides the outcome. If the new depth is strictly nearer, the select bit flips. Otherwise the idle slot is left holding a value that nobody reads.

The test therefore takes two stages. A request may not follow a request of the same column parity in the next cycle. Even and odd columns take turns between the stages, so span traffic along consecutive columns keeps one comparison per clock. A one-cycle clear and a sequential read-out of the resolved span IDs complete the block. Span ID 0 is the null pointer.

Top module: `scanline_zbuf`

## Requirements
- R1: After reset, every pixel holds the maximum depth (all ones) and the null span ID 0, and `req_ready` is high while the block is idle.
- R2: An accepted request whose depth is strictly less than the pixel's current depth becomes the pixel's current depth and span ID. It is visible to any request or read-out that starts from the second cycle after acceptance.
- R3: An accepted request whose depth is equal to or greater than the current depth leaves the pixel's depth and span ID unchanged. This includes a maximum-depth request against a cleared pixel.
- R4: When consecutive requests alternate between even and odd columns (`req_x[0]` differs), a request is accepted in every cycle with no stall.
- R5: When a request has the same column parity as the request accepted in the cycle before, `req_ready` is low for exactly one cycle, and the request is accepted in the cycle after that.
- R6: Successive requests to one pixel are each compared against the result of the requests before them. The pixel ends with the span ID of the earliest request that carries the minimum depth, so ties keep the older entry.
- R7: While `clr` is high, `req_ready` is low. After the clock edge, every pixel is back to the maximum depth and span ID 0, and a compare still in flight is discarded.
- R8: A `rd_start` pulse on an idle cycle produces, from the second cycle after it, WIDTH consecutive cycles of `out_valid`. In those cycles `out_x` runs from 0 to WIDTH-1 and `out_span` carries each pixel's current span ID. `req_ready` stays low from the pulse until the last pixel has been read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, same effect as a clear |
| clr | input | 1 | One-cycle scanline clear |
| req_valid | input | 1 | Depth-test request present |
| req_ready | output | 1 | Request accepted at this clock edge when high together with req_valid |
| req_x | input | XW | Pixel column, below WIDTH |
| req_z | input | ZW | New depth, smaller is nearer |
| req_span | input | SW | Span ID of the candidate surface |
| rd_start | input | 1 | Start streaming the resolved scanline |
| out_valid | output | 1 | Read-out data valid |
| out_x | output | XW | Column of the read-out pixel |
| out_span | output | SW | Current span ID of that pixel |

## Verification
The bench sweeps every pair of 4-bit depths on the same pixel. A design that accepted ties would hand the pixel to the later span, and one that compared against the wrong slot would keep stale winners. It counts stalls on alternating-parity and same-parity streams. A design without the parity hazard check would compare against a select bit that had not yet been updated. One that stalled too eagerly would lose the one-per-clock rate. Chained hits on one pixel, a clear of a full line, and a randomised mixed stream end in read-outs checked column by column. A wrong read order or a missed clear shows up as a mismatched span ID.

// File: rtl/scanline_zbuf.sv
module scanline_zbuf #(
  parameter int WIDTH = 16,
  parameter int ZW    = 16,
  parameter int SW    = 8,
  localparam int XW   = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [XW-1:0] req_x,
  input  logic [ZW-1:0] req_z,
  input  logic [SW-1:0] req_span,
  input  logic          rd_start,
  output logic          out_valid,
  output logic [XW-1:0] out_x,
  output logic [SW-1:0] out_span
);

  logic [ZW-1:0]    dep [2][WIDTH];
  logic [SW-1:0]    spn [2][WIDTH];
  logic [WIDTH-1:0] sel;

  logic          s2_v;
  logic [XW-1:0] s2_x;
  logic [ZW-1:0] s2_z, s2_cur;

  logic          rd_busy;
  logic [XW-1:0] rd_cnt;

  wire accept = req_valid && req_ready;
  wire win    = s2_z < s2_cur;

  assign req_ready = !clr && !rd_busy && !rd_start && !(s2_v && s2_x[0] == req_x[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel       <= '0;
      s2_v      <= 1'b0;
      s2_x      <= '0;
      s2_z      <= '0;
      s2_cur    <= '0;
      rd_busy   <= 1'b0;
      rd_cnt    <= '0;
      out_valid <= 1'b0;
      out_x     <= '0;
      out_span  <= '0;
      for (int i = 0; i < WIDTH; i++) begin
        dep[0][XW'(i)] <= '1;
        dep[1][XW'(i)] <= '1;
        spn[0][XW'(i)] <= '0;
        spn[1][XW'(i)] <= '0;
      end
    end else begin
      out_valid <= rd_busy;
      if (rd_busy) begin
        out_x    <= rd_cnt;
        out_span <= spn[sel[rd_cnt]][rd_cnt];
        rd_cnt   <= rd_cnt + 1'b1;
        if (rd_cnt == XW'(WIDTH - 1)) rd_busy <= 1'b0;
      end
      if (clr) begin
        sel  <= '0;
        s2_v <= 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
          dep[0][XW'(i)] <= '1;
          spn[0][XW'(i)] <= '0;
        end
      end else begin
        if (s2_v && win) sel[s2_x] <= ~sel[s2_x];
        s2_v <= accept;
        if (accept) begin
          dep[!sel[req_x]][req_x] <= req_z;
          spn[!sel[req_x]][req_x] <= req_span;
          s2_x   <= req_x;
          s2_z   <= req_z;
          s2_cur <= dep[sel[req_x]][req_x];
        end
        if (rd_start && !rd_busy) begin
          rd_busy <= 1'b1;
          rd_cnt  <= '0;
        end
      end
    end
  end

  assert_no_flip_on_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && s2_v && !win) |=> sel == $past(sel));

  assert_single_flip_on_win_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && s2_v && win) |=> $countones(sel ^ $past(sel)) == 1);

  assert_parity_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !(req_valid && req_ready && req_x[0] == $past(req_x[0])));

  assert_alternate_flows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!req_valid || clr || rd_start || rd_busy || req_x[0] == $past(req_x[0]) || req_ready));

  assert_clear_resets_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sel == '0 && !s2_v));

  assert_readout_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |=> out_valid);

  assert_readout_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> out_x == $past(out_x) + 1'b1);

endmodule

// File: tb/tb_scanline_zbuf.sv
`timescale 1ns/1ps
module tb_scanline_zbuf;
  localparam int W = 8, ZW = 4, SW = 3, XW = 3;

  logic clk = 0, rst_n = 0, clr = 0, req_valid = 0, rd_start = 0;
  logic [XW-1:0] req_x = '0;
  logic [ZW-1:0] req_z = '0;
  logic [SW-1:0] req_span = '0;
  logic req_ready, out_valid;
  logic [XW-1:0] out_x;
  logic [SW-1:0] out_span;

  int total = 0, bad = 0;
  int mz[W], ms[W];

  always #2.5 clk = ~clk;

  scanline_zbuf #(.WIDTH(W), .ZW(ZW), .SW(SW)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .req_valid(req_valid), .req_ready(req_ready),
    .req_x(req_x), .req_z(req_z), .req_span(req_span), .rd_start(rd_start),
    .out_valid(out_valid), .out_x(out_x), .out_span(out_span));

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < W; i++) begin mz[i] = 15; ms[i] = 0; end
  endtask

  task automatic send(int x, int z, int s, inout int st);
    @(negedge clk);
    req_valid = 1; req_x = XW'(x); req_z = ZW'(z); req_span = SW'(s);
    #1;
    while (!req_ready) begin st++; @(negedge clk); #1; end
    @(posedge clk);
    if (z < mz[x]) begin mz[x] = z; ms[x] = s; end
  endtask

  task automatic idle();
    @(negedge clk); req_valid = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); req_valid = 0; clr = 1; #1;
    check(!req_ready, "R7 ready during clear", req_ready, 0);
    @(negedge clk); clr = 0;
    model_clear();
  endtask

  task automatic readout(string tag);
    int n = 0;
    @(negedge clk); req_valid = 0; rd_start = 1;
    @(negedge clk); rd_start = 0; #1;
    check(!req_ready, "R8 ready during readout", req_ready, 0);
    for (int c = 0; c < W + 4; c++) begin
      @(negedge clk);
      if (out_valid) begin
        if (n < W) begin
          check(out_x == XW'(n), "R8 column order", out_x, n);
          check(out_span == SW'(ms[n]), tag, out_span, ms[n]);
        end
        n++;
      end else if (n > 0 && n < W) begin
        check(0, "R8 gap in readout", n, W);
        n = W + 1;
      end
    end
    check(n == W, "R8 readout length", n, W);
  endtask

  initial begin
    int st;
    logic [7:0] lf;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(req_ready, "R1 ready after reset", req_ready, 1);
    readout("R1 reset contents");

    // R2 R3 R6: every pair of depths on one pixel
    for (int z1 = 0; z1 < 16; z1++) begin
      for (int h = 0; h < 2; h++) begin
        do_clear();
        st = 0;
        for (int x = 0; x < W; x++) begin
          send(x, z1, 1, st);
          send(x, h * 8 + x, 2, st);
        end
        idle();
        readout("R2 R3 pair resolve");
      end
    end

    // R4: alternating parity, no stalls
    do_clear();
    st = 0;
    for (int x = 0; x < W; x++) send(x, 10 - x, x + 1, st);
    idle();
    check(st == 0, "R4 alternating stalls", st, 0);
    readout("R4 stream contents");

    // R5: same parity back to back
    do_clear();
    st = 0;
    send(0, 3, 1, st); send(2, 3, 2, st); send(4, 3, 3, st); send(6, 3, 4, st);
    idle();
    check(st == 3, "R5 same parity stalls", st, 3);
    readout("R5 stream contents");

    // R6: chain on one pixel with a tie
    do_clear();
    st = 0;
    send(3, 9, 1, st); send(3, 5, 2, st); send(3, 7, 3, st); send(3, 5, 4, st); send(3, 2, 5, st); send(3, 2, 6, st);
    idle();
    check(ms[3] == 5, "R6 model chain", ms[3], 5);
    readout("R6 chained pixel");

    // R7: clear after a full line
    st = 0;
    for (int x = 0; x < W; x++) send(x, 1, 7, st);
    do_clear();
    readout("R7 cleared contents");

    // mixed random stream
    lf = 8'h5a;
    st = 0;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      send(int'(lf[2:0]), int'(lf[7:4]), int'(lf[5:3]) | 1, st);
    end
    idle();
    readout("R2 R6 random stream");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule